// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. An internal tick runs at a set multiple of the bit rate, by default sixteen ticks per bit. A falling edge on the idle-high line starts a frame. The start bit is re-sampled halfway through to reject short glitches. Every following bit is then sampled once, at the middle of its bit time.

The character length, the parity mode and the number of stop bits are configuration inputs. They are held steady while a frame is on the line. Each finished character is placed in a single holding register together with a parity-error flag and a framing-error flag. The register stays valid until the consumer pulses a read strobe.

A ready output tells the far end whether another character can be accepted. It is high whenever the holding register is empty. After a frame the receiver does not look for a new start bit until the line has gone back to idle. A line held low after a bad stop bit therefore never produces spurious characters.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `valid_o`, `perr_o` and `ferr_o` are 0 and `rtr_o` is 1.
- R2: The line idles at 1. A frame is a 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. `len_i` holds the number of data bits minus one (4 to 7 for 5 to 8 bits). `data_o` holds the character right-aligned, with the unused upper bits 0.
- R3: A low pulse shorter than half a bit time is seen again as high at the half-bit check. It returns the receiver to idle and delivers no character.
- R4: `parity_i` selects the parity mode: 0 none (no parity bit on the line), 1 even, 2 odd, 3 forced 1, 4 forced 0. Codes 5 to 7 act as none. `perr_o` is 1 with a character whose received parity bit differs from the value the mode expects, and 0 otherwise.
- R5: In even or odd mode, a single inverted data bit makes `perr_o` 1 for that character.
- R6: With `two_stop_i` at 0 the frame has one stop bit; with it at 1 the frame has two. `ferr_o` is 1 with the delivered character if any stop bit was sampled as 0.
- R7: After the last stop bit, the receiver re-arms only once the line has been seen high. A line held low produces no further characters.
- R8: A delivered character stays on `data_o` with `valid_o` high until `rd_i` is pulsed. `rtr_o` is low exactly while the holding register is full.
- R9: A character that completes while the holding register is full and not being read is discarded, and the held character and its flags are unchanged.
- R10: One bit time lasts OVS × (`div_i` + 1) clock cycles, with OVS = 16 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Clock cycles per oversample tick, minus one |
| len_i | input | $clog2(DATA_MAX) | Data bit count minus one |
| parity_i | input | 3 | Parity mode code |
| two_stop_i | input | 1 | 1 selects two stop bits |
| rd_i | input | 1 | Read strobe that empties the holding register |
| data_o | output | DATA_MAX | Held character |
| valid_o | output | 1 | Holding register full |
| perr_o | output | 1 | Parity error of the held character |
| ferr_o | output | 1 | Framing error of the held character |
| rtr_o | output | 1 | Ready to receive another character |

## Verification
The assertions assume that `div_i`, `len_i`, `parity_i` and `two_stop_i` change only while the line is idle between frames. They also assume that `div_i` is never zero, so ticks are spaced at least two cycles apart. The stimulus writes the configuration only before it drives a start bit, and it changes the divisor only after every pending character has been drained. It uses divisors of 3 and 1.

// File: rtl/scr_pkg.sv
package scr_pkg;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_EVEN  = 3'd1,
      PAR_ODD   = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAIT
   } rx_state_e;

   // Parity bit value a mode expects, given the XOR of the data bits.
   function automatic logic par_expected(input logic [2:0] mode, input logic xor_all);
      logic r;
      case (mode)
         PAR_EVEN:  r = xor_all;
         PAR_ODD:   r = ~xor_all;
         PAR_MARK:  r = 1'b1;
         PAR_SPACE: r = 1'b0;
         default:   r = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic par_present(input logic [2:0] mode);
      return (mode >= PAR_EVEN) && (mode <= PAR_SPACE);
   endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= d_i;
         end
         assign q_o = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], d_i};
         end
         assign q_o = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/scr_baud_tick.sv
module scr_baud_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt;

   assign tick_o = (cnt >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (tick_o) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   // R10: with a non-zero divisor, ticks never fall on consecutive cycles
   a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/scr_frame_fsm.sv
module scr_frame_fsm
   import scr_pkg::*;
#(
   parameter int DATA_MAX = 8,
   parameter int OVS      = 16,
   parameter int LEN_W    = $clog2(DATA_MAX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                rx_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic [2:0]          mode_i,
   input  logic                two_stop_i,
   output logic [DATA_MAX-1:0] char_o,
   output logic                perr_o,
   output logic                ferr_o,
   output logic                done_o
);
   localparam int OVS_W = $clog2(OVS);
   localparam int HALF  = OVS / 2;

   rx_state_e           state;
   logic [OVS_W-1:0]    ovs_cnt;
   logic [LEN_W-1:0]    bit_cnt;
   logic                stop_cnt;
   logic [DATA_MAX-1:0] shreg;
   logic                par_bit;
   logic                ferr_q;
   logic                last_ovs;
   logic                par_en;
   logic [DATA_MAX-1:0] aligned;

   assign last_ovs = tick_i && (ovs_cnt == OVS_W'(OVS - 1));
   assign par_en   = par_present(mode_i);
   assign aligned  = shreg >> (LEN_W'(DATA_MAX - 1) - len_i);

   assign char_o = aligned;
   assign perr_o = par_en && (par_bit != par_expected(mode_i, ^aligned));
   assign ferr_o = ferr_q | ~rx_i;
   assign done_o = last_ovs && (state == ST_STOP) && (!two_stop_i || stop_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ovs_cnt  <= '0;
         bit_cnt  <= '0;
         stop_cnt <= 1'b0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         ferr_q   <= 1'b0;
      end else if (tick_i) begin
         case (state)
            ST_IDLE: begin
               if (!rx_i) begin
                  state   <= ST_START;
                  ovs_cnt <= '0;
               end
            end
            ST_START: begin
               if (ovs_cnt == OVS_W'(HALF - 1)) begin
                  ovs_cnt <= '0;
                  bit_cnt <= '0;
                  state   <= rx_i ? ST_IDLE : ST_DATA;
               end else begin
                  ovs_cnt <= ovs_cnt + 1'b1;
               end
            end
            ST_DATA: begin
               ovs_cnt <= ovs_cnt + 1'b1;
               if (last_ovs) begin
                  shreg <= {rx_i, shreg[DATA_MAX-1:1]};
                  if (bit_cnt == len_i) begin
                     state    <= par_en ? ST_PAR : ST_STOP;
                     stop_cnt <= 1'b0;
                     ferr_q   <= 1'b0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               ovs_cnt <= ovs_cnt + 1'b1;
               if (last_ovs) begin
                  par_bit <= rx_i;
                  state   <= ST_STOP;
               end
            end
            ST_STOP: begin
               ovs_cnt <= ovs_cnt + 1'b1;
               if (last_ovs) begin
                  if (!rx_i) ferr_q <= 1'b1;
                  if (two_stop_i && !stop_cnt) stop_cnt <= 1'b1;
                  else                         state    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rx_i) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: a frame can only begin from a low line
   a_r3_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && rx_i) |=> state != ST_START);

   // R7: no re-arm while the line stays low after a frame
   a_r7_rearm_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !rx_i) |=> state == ST_WAIT);
endmodule

// File: rtl/scr_hold.sv
module scr_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         perr_i,
   input  logic         ferr_i,
   input  logic         rd_i,
   output logic [W-1:0] data_o,
   output logic         perr_o,
   output logic         ferr_o,
   output logic         valid_o
);
   logic accept;

   assign accept = load_i && (!valid_o || rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
         valid_o <= 1'b0;
      end else if (accept) begin
         data_o  <= data_i;
         perr_o  <= perr_i;
         ferr_o  <= ferr_i;
         valid_o <= 1'b1;
      end else if (rd_i) begin
         valid_o <= 1'b0;
      end
   end

   // R8: a held character stays valid until it is read
   a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !rd_i) |=> valid_o);

   // R9: an unread character is never overwritten
   a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !rd_i) |=> ($stable(data_o) && $stable(perr_o) && $stable(ferr_o)));
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
   parameter int DATA_MAX    = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(DATA_MAX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rxd_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic [2:0]          parity_i,
   input  logic                two_stop_i,
   input  logic                rd_i,
   output logic [DATA_MAX-1:0] data_o,
   output logic                valid_o,
   output logic                perr_o,
   output logic                ferr_o,
   output logic                rtr_o
);
   initial begin : p_elab_checks
      assert (DATA_MAX >= 2) else $error("DATA_MAX must be at least 2");
      assert (OVS >= 4 && (OVS & (OVS - 1)) == 0) else $error("OVS must be a power of two, at least 4");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES must be 0 to 4");
      assert (DIV_W >= 1) else $error("DIV_W must be positive");
   end

   logic                rx_s;
   logic                tick;
   logic [DATA_MAX-1:0] chr;
   logic                c_perr;
   logic                c_ferr;
   logic                done;

   scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s)
   );

   scr_baud_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div_i(div_i), .tick_o(tick)
   );

   scr_frame_fsm #(.DATA_MAX(DATA_MAX), .OVS(OVS), .LEN_W(LEN_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
      .len_i(len_i), .mode_i(parity_i), .two_stop_i(two_stop_i),
      .char_o(chr), .perr_o(c_perr), .ferr_o(c_ferr), .done_o(done)
   );

   scr_hold #(.W(DATA_MAX)) u_hold (
      .clk(clk), .rst_n(rst_n), .load_i(done), .data_i(chr),
      .perr_i(c_perr), .ferr_i(c_ferr), .rd_i(rd_i),
      .data_o(data_o), .perr_o(perr_o), .ferr_o(ferr_o), .valid_o(valid_o)
   );

   assign rtr_o = ~valid_o;
endmodule

// File: tb/serial_char_rx_tb.sv
module serial_char_rx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rxd = 1'b1;
   logic [15:0] div = 16'd3;
   logic [2:0]  len = 3'd7;
   logic [2:0]  par = 3'd0;
   logic        two = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  data_o;
   logic        valid_o, perr_o, ferr_o, rtr_o;

   int   checks = 0;
   int   errors = 0;
   int   bitclk = 64;
   bit   auto_read = 1'b0;
   logic [9:0] expq[$];

   always #10 clk = ~clk;

   serial_char_rx u_dut (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .div_i(div), .len_i(len),
      .parity_i(par), .two_stop_i(two), .rd_i(rd),
      .data_o(data_o), .valid_o(valid_o), .perr_o(perr_o), .ferr_o(ferr_o), .rtr_o(rtr_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic parbit(input logic [2:0] m, input logic [7:0] x);
      case (m)
         3'd1:    return ^x;
         3'd2:    return ~^x;
         3'd3:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Behavioural model of the holding register: readiness mirrors emptiness,
   // and each delivered character must match the next queued expectation.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rtr_o !== !valid_o) chk(1'b0, "R8", "ready vs full", {31'd0, rtr_o}, {31'd0, !valid_o});
         if (rd) rd = 1'b0;
         else if (valid_o && auto_read) begin
            if (expq.size() == 0) chk(1'b0, "R7", "unexpected character", {22'd0, ferr_o, perr_o, data_o}, 0);
            else begin
               logic [9:0] e;
               e = expq.pop_front();
               chk({ferr_o, perr_o, data_o} == e, "R2/R4/R6", "character and flags",
                   {22'd0, ferr_o, perr_o, data_o}, {22'd0, e});
            end
            rd = 1'b1;
         end
      end
   end

   task automatic drive(input logic b);
      @(posedge clk);
      #1 rxd = b;
      repeat (bitclk - 1) @(posedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int n, input logic [2:0] m, input bit tw,
                             input logic [7:0] flip, input bit pinv, input bit s1, input bit s2,
                             input int low_after, input bit exp_it);
      logic [7:0] mask;
      logic [7:0] tx;
      logic       txp;
      bit         has_p;
      bit         pe;
      bit         fe;
      mask  = 8'hFF >> (8 - n);
      tx    = (d ^ flip) & mask;
      has_p = (m >= 3'd1) && (m <= 3'd4);
      txp   = parbit(m, d & mask) ^ pinv;
      pe    = has_p && (txp != parbit(m, tx));
      fe    = !s1 || (tw && !s2);
      len = 3'(n - 1);
      par = m;
      two = tw;
      if (exp_it) expq.push_back({fe, pe, tx});
      drive(1'b0);
      for (int i = 0; i < n; i++) drive(tx[i]);
      if (has_p) drive(txp);
      drive(s1);
      if (tw) drive(s2);
      for (int i = 0; i < low_after; i++) drive(1'b0);
      drive(1'b1);
   endtask

   task automatic drain(input string req);
      int t;
      t = 0;
      while ((expq.size() != 0 || valid_o) && t < 5000) begin
         @(posedge clk);
         t++;
      end
      @(negedge clk);
      chk(expq.size() == 0, req, "pending characters", expq.size(), 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(valid_o == 1'b0, "R1", "valid after reset", {31'd0, valid_o}, 0);
      chk(rtr_o == 1'b1, "R1", "ready after reset", {31'd0, rtr_o}, 1);
      chk(perr_o == 1'b0 && ferr_o == 1'b0, "R1", "flags after reset", {30'd0, perr_o, ferr_o}, 0);
      rst_n = 1'b1;
      auto_read = 1'b1;
      repeat (2) drive(1'b1);

      // R2: plain frames of every length
      send_frame(8'hA5, 8, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h3C, 8, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'hF5, 5, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h2A, 6, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h5A, 7, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      drain("R2");

      // R4: each parity mode, correct bit; code 5 behaves as none
      send_frame(8'h37, 8, 3'd1, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h37, 8, 3'd2, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h81, 8, 3'd3, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h81, 8, 3'd4, 0, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h6E, 8, 3'd5, 0, 8'h00, 0, 1, 1, 0, 1);
      // R4: forced-1 and forced-0 modes with the wrong bit on the line
      send_frame(8'h44, 8, 3'd3, 0, 8'h00, 1, 1, 1, 0, 1);
      send_frame(8'h44, 8, 3'd4, 0, 8'h00, 1, 1, 1, 0, 1);
      drain("R4");

      // R5: one inverted data bit under even and odd parity
      send_frame(8'hC3, 8, 3'd1, 0, 8'h10, 0, 1, 1, 0, 1);
      send_frame(8'hC3, 8, 3'd2, 0, 8'h01, 0, 1, 1, 0, 1);
      send_frame(8'h55, 7, 3'd2, 0, 8'h40, 0, 1, 1, 0, 1);
      drain("R5");

      // R6: stop-bit count and framing errors
      send_frame(8'h9D, 8, 3'd0, 1, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h9D, 8, 3'd0, 0, 8'h00, 0, 0, 1, 0, 1);
      send_frame(8'h71, 8, 3'd1, 1, 8'h00, 0, 1, 0, 0, 1);
      send_frame(8'h71, 8, 3'd0, 1, 8'h00, 0, 0, 1, 0, 1);
      drain("R6");

      // R3: a quarter-bit glitch delivers nothing
      @(posedge clk);
      #1 rxd = 1'b0;
      repeat (bitclk / 4) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (3 * bitclk) @(posedge clk);
      @(negedge clk);
      chk(valid_o == 1'b0, "R3", "glitch produced character", {31'd0, valid_o}, 0);
      send_frame(8'h0F, 8, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      drain("R3");

      // R7: bad stop followed by a long low line, then a normal frame
      send_frame(8'h6B, 8, 3'd0, 0, 8'h00, 0, 0, 1, 20, 1);
      drive(1'b1);
      send_frame(8'hB2, 8, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      drain("R7");

      // R8 / R9: full holding register, second character dropped
      auto_read = 1'b0;
      send_frame(8'h5E, 8, 3'd0, 0, 8'h00, 0, 1, 1, 0, 1);
      drive(1'b1);
      @(negedge clk);
      chk(valid_o == 1'b1 && rtr_o == 1'b0, "R8", "full and not ready", {30'd0, valid_o, rtr_o}, 32'h2);
      chk(data_o == 8'h5E, "R8", "held character", {24'd0, data_o}, 32'h5E);
      send_frame(8'h81, 8, 3'd0, 0, 8'h00, 0, 0, 1, 0, 0);
      drive(1'b1);
      @(negedge clk);
      chk(data_o == 8'h5E && ferr_o == 1'b0, "R9", "held character kept", {23'd0, ferr_o, data_o}, 32'h5E);
      chk(valid_o == 1'b1, "R9", "still valid", {31'd0, valid_o}, 1);
      auto_read = 1'b1;
      drain("R8");
      chk(rtr_o == 1'b1, "R8", "ready after read", {31'd0, rtr_o}, 1);

      // R10: faster divisor gives a 32-cycle bit
      div = 16'd1;
      bitclk = 32;
      repeat (2) drive(1'b1);
      send_frame(8'hE7, 8, 3'd2, 1, 8'h00, 0, 1, 1, 0, 1);
      send_frame(8'h19, 6, 3'd1, 0, 8'h00, 0, 1, 1, 0, 1);
      drain("R10");

      finish_run();
   end
endmodule